// File: doc/BRIEF.md
# Relocating Address Window with Range Trap

This block sits between an address generator and main memory. It turns every address a program produces into a physical address by adding a relocation base. It also refuses any access that falls outside the window the running program was given. The window is described by one register that holds a base and a size. Every reference goes through the same path: instruction fetches and data accesses, in supervisor mode and in user mode alike. For that reason the block has no mode input at all.

Each request is checked against two limits. The first is the window size: the relative address must be strictly below it, because the size is a count of words and not the last legal address. The second is the installed physical memory: the relocated address must be strictly below the memory size. The sum is formed one bit wider than an address, so a base plus offset that overflows the address width counts as out of range instead of wrapping. A request that passes both limits is granted and its physical address is presented. A request that fails either limit produces a one-cycle memory-trap pulse, and no grant is given, so nothing reaches memory.

The window register is written through a privileged port. A write is seen by requests sampled on later edges, never by a request sampled on the same edge. Reset opens the whole memory: base 0 and size equal to the memory size.

Top module: `rb_xlate`

## Requirements
- R1: After reset the window has base 0 and size MEM_WORDS (40000 by default). Relative address MEM_WORDS-1 is then granted at physical address MEM_WORDS-1, and address MEM_WORDS traps.
- R2: A request sampled with `req_valid` high on a rising edge gives its result on `grant`, `mem_trap` and `phys_addr` after that same edge. A cycle without a request gives `grant`=0, `mem_trap`=0 and `phys_addr`=0.
- R3: A granted request presents `phys_addr` equal to the window base plus the relative address.
- R4: A request whose base plus relative address is greater than or equal to MEM_WORDS traps, even when the relative address is inside the window size.
- R5: The window size is a count of words. A relative address equal to size-1 is granted, and a relative address equal to the size or above it traps.
- R6: The base-plus-address sum is evaluated at PA_W+1 bits. A sum that exceeds the PA_W-bit range traps rather than wrapping to a small legal address.
- R7: `grant` and `mem_trap` are never high together. While `mem_trap` is high, `phys_addr` is 0.
- R8: When `cfg_wr` is high on a rising edge, base becomes `cfg_base` and size becomes `cfg_bound` from that edge onward. A request sampled on the same edge is checked against the old window.
- R9: A window size of 0 traps every request, including relative address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A memory reference is presented this cycle |
| req_addr | input | PA_W | Program-relative address |
| cfg_wr | input | 1 | Privileged write strobe for the window register |
| cfg_base | input | PA_W | New relocation base |
| cfg_bound | input | PA_W+1 | New window size in words |
| phys_addr | output | PA_W | Relocated address, valid with grant |
| grant | output | 1 | Access may proceed to memory |
| mem_trap | output | 1 | One-cycle pulse: access outside window or memory |

## Verification
The bench hits the limits on both sides of each edge. It uses relative address size-1 against size, and base+address just below and exactly at the memory size. A design that treats the size as a last address, or that uses greater-than in place of greater-or-equal, grants the extra word. The bench picks a base near the top of the address range so that the sum overflows PA_W bits; a design that drops the carry wraps the sum and grants a bogus low address. It puts a request on the same edge as a register write, which exposes a design that bypasses the new window into that request. It also uses a size of 0, which must trap even relative address 0.

// File: rtl/rb_xlate_pkg.sv
// Shared types for the relocating address window.
// Assumes: nothing beyond standard SystemVerilog packages.
package rb_xlate_pkg;

    // Outcome of one request as judged by the limit checker.
    typedef enum logic [1:0] {
        VERDICT_IDLE  = 2'b00,
        VERDICT_GRANT = 2'b01,
        VERDICT_TRAP  = 2'b10
    } verdict_e;

endpackage

// File: rtl/rb_window_reg.sv
// Holds the relocation base and window size.
// Assumes: the writer is privileged; no mode is checked here.
// Reset opens the full memory (base 0, size RST_BOUND).
module rb_window_reg #(
    parameter int PA_W      = 16,
    parameter int BND_W     = PA_W + 1,
    parameter int RST_BOUND = 40000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [BND_W-1:0] wr_bound,
    output logic [PA_W-1:0]  base_q,
    output logic [BND_W-1:0] bound_q
);

    localparam logic [BND_W-1:0] RST_BND = BND_W'(RST_BOUND);

    // Load the window on a write strobe, restore the full window on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            bound_q <= RST_BND;
        end else if (wr_en) begin
            base_q  <= wr_base;
            bound_q <= wr_bound;
        end
    end

endmodule

// File: rtl/rb_limit_check.sv
// Forms base+address at PA_W+1 bits and judges the request against
// the window size and the physical memory size.
// Assumes: MEM_WORDS is at most 2**PA_W. When it equals 2**PA_W, the
// memory check reduces to the carry bit, and a generate branch picks
// that cheaper form.
module rb_limit_check
    import rb_xlate_pkg::*;
#(
    parameter int PA_W      = 16,
    parameter int BND_W     = PA_W + 1,
    parameter int MEM_WORDS = 40000
) (
    input  logic             valid,
    input  logic [PA_W-1:0]  addr,
    input  logic [PA_W-1:0]  base,
    input  logic [BND_W-1:0] bound,
    output logic [PA_W-1:0]  phys,
    output verdict_e         verdict
);

    localparam int SUM_W = PA_W + 1;
    localparam logic [SUM_W-1:0] MEM_LIM = SUM_W'(MEM_WORDS);

    logic [SUM_W-1:0] sum_w;
    logic             over_mem;
    logic             over_bound;

    // Widened add so that a carry out of PA_W bits is kept.
    always_comb begin
        sum_w = {1'b0, addr} + {1'b0, base};
    end

    generate
        if (MEM_WORDS == (1 << PA_W)) begin : g_full_map
            // Memory fills the address range: only the carry can exceed it.
            always_comb begin
                over_mem = sum_w[PA_W];
            end
        end else begin : g_part_map
            // Compare the widened sum with the memory size.
            always_comb begin
                over_mem = (sum_w >= MEM_LIM);
            end
        end
    endgenerate

    // The window size is a count, so address == size is already outside.
    always_comb begin
        over_bound = (BND_W'(addr) >= bound);
    end

    // Combine both limits into one verdict and the relocated address.
    always_comb begin
        phys = sum_w[PA_W-1:0];
        if (!valid)
            verdict = VERDICT_IDLE;
        else if (over_mem || over_bound)
            verdict = VERDICT_TRAP;
        else
            verdict = VERDICT_GRANT;
    end

endmodule

// File: rtl/rb_result_stage.sv
// Registers the verdict into the grant, trap and address outputs.
// Assumes: a verdict arrives every cycle; the address is forced to zero
// unless the request is granted, so a trapped address never leaves.
module rb_result_stage
    import rb_xlate_pkg::*;
#(
    parameter int PA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  verdict_e        verdict,
    input  logic [PA_W-1:0] phys_in,
    output logic [PA_W-1:0] phys_out,
    output logic            grant,
    output logic            trap
);

    // Capture the outcome of the request sampled on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_out <= '0;
            grant    <= 1'b0;
            trap     <= 1'b0;
        end else begin
            grant    <= (verdict == VERDICT_GRANT);
            trap     <= (verdict == VERDICT_TRAP);
            phys_out <= (verdict == VERDICT_GRANT) ? phys_in : '0;
        end
    end

endmodule

// File: rtl/rb_xlate.sv
// Top level of the relocating address window.
// Every reference, whatever the processor mode, is relocated by the base
// and checked against the window size and the memory size. The result
// appears one edge after the request is sampled.
// Assumes: the window register is written only by privileged software.
module rb_xlate #(
    parameter int PA_W      = 16,
    parameter int MEM_WORDS = 40000,
    parameter int BND_W     = PA_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [PA_W-1:0]  req_addr,
    input  logic             cfg_wr,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [BND_W-1:0] cfg_bound,
    output logic [PA_W-1:0]  phys_addr,
    output logic             grant,
    output logic             mem_trap
);

    import rb_xlate_pkg::*;

    logic [PA_W-1:0]  base_q;
    logic [BND_W-1:0] bound_q;
    logic [PA_W-1:0]  phys_c;
    verdict_e         verdict_c;

    rb_window_reg #(
        .PA_W      (PA_W),
        .BND_W     (BND_W),
        .RST_BOUND (MEM_WORDS)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_base  (cfg_base),
        .wr_bound (cfg_bound),
        .base_q   (base_q),
        .bound_q  (bound_q)
    );

    rb_limit_check #(
        .PA_W      (PA_W),
        .BND_W     (BND_W),
        .MEM_WORDS (MEM_WORDS)
    ) u_check (
        .valid   (req_valid),
        .addr    (req_addr),
        .base    (base_q),
        .bound   (bound_q),
        .phys    (phys_c),
        .verdict (verdict_c)
    );

    rb_result_stage #(
        .PA_W (PA_W)
    ) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .verdict  (verdict_c),
        .phys_in  (phys_c),
        .phys_out (phys_addr),
        .grant    (grant),
        .trap     (mem_trap)
    );

endmodule

// File: rtl/rb_xlate_chk.sv
// Property checker for rb_xlate, attached to every instance by bind.
module rb_xlate_chk #(
    parameter int PA_W      = 16,
    parameter int MEM_WORDS = 40000,
    parameter int BND_W     = PA_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [PA_W-1:0]  req_addr,
    input logic             cfg_wr,
    input logic [PA_W-1:0]  cfg_base,
    input logic [BND_W-1:0] cfg_bound,
    input logic [PA_W-1:0]  phys_addr,
    input logic             grant,
    input logic             mem_trap,
    input logic [PA_W-1:0]  base_q,
    input logic [BND_W-1:0] bound_q
);

    // R1
    reset_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (base_q == '0) && (bound_q == BND_W'(MEM_WORDS)));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !grant && !mem_trap && (phys_addr == '0));

    // R4
    phys_in_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ((PA_W+1)'(phys_addr) < (PA_W+1)'(MEM_WORDS)));

    // R5
    over_size_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (BND_W'(req_addr) >= bound_q)) |=> mem_trap);

    // R7
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant, mem_trap}));

    // R7
    trap_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_trap |-> (phys_addr == '0));

    // R8
    window_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (base_q == $past(cfg_base)) && (bound_q == $past(cfg_bound)));

endmodule

bind rb_xlate rb_xlate_chk #(
    .PA_W      (PA_W),
    .MEM_WORDS (MEM_WORDS),
    .BND_W     (BND_W)
) u_rb_xlate_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .cfg_wr    (cfg_wr),
    .cfg_base  (cfg_base),
    .cfg_bound (cfg_bound),
    .phys_addr (phys_addr),
    .grant     (grant),
    .mem_trap  (mem_trap),
    .base_q    (base_q),
    .bound_q   (bound_q)
);

// File: tb/test_rb_xlate.sv
// Scoreboard bench: the driver computes each expected result and queues
// it; the monitor compares it mid-cycle after the capturing edge.
module test_rb_xlate;

    localparam int PA_W      = 16;
    localparam int MEM_WORDS = 40000;
    localparam int BND_W     = PA_W + 1;

    typedef struct {
        logic        grant;
        logic        trap;
        int unsigned phys;
        string       req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [PA_W-1:0]  req_addr = '0;
    logic             cfg_wr = 1'b0;
    logic [PA_W-1:0]  cfg_base = '0;
    logic [BND_W-1:0] cfg_bound = '0;
    logic [PA_W-1:0]  phys_addr;
    logic             grant;
    logic             mem_trap;

    int          n_cmp = 0;
    int          n_bad = 0;
    exp_t        sb_q[$];
    int unsigned m_base;
    int unsigned m_bound;

    always #10 clk = ~clk;

    rb_xlate #(
        .PA_W      (PA_W),
        .MEM_WORDS (MEM_WORDS),
        .BND_W     (BND_W)
    ) i_rb_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .cfg_wr    (cfg_wr),
        .cfg_base  (cfg_base),
        .cfg_bound (cfg_bound),
        .phys_addr (phys_addr),
        .grant     (grant),
        .mem_trap  (mem_trap)
    );

    task automatic report_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // One cycle of stimulus; the expected result uses the window held before this edge.
    task automatic drive(input bit v, input int unsigned a, input bit w,
                         input int unsigned wb, input int unsigned wz, input string req);
        exp_t e;
        int unsigned sum;
        @(negedge clk);
        req_valid = v;
        req_addr  = PA_W'(a);
        cfg_wr    = w;
        cfg_base  = PA_W'(wb);
        cfg_bound = BND_W'(wz);
        sum = a + m_base;
        e.req = req;
        if (!v) begin
            e.grant = 0; e.trap = 0; e.phys = 0;
        end else if (sum >= MEM_WORDS || a >= m_bound) begin
            e.grant = 0; e.trap = 1; e.phys = 0;
        end else begin
            e.grant = 1; e.trap = 0; e.phys = sum;
        end
        sb_q.push_back(e);
        if (w) begin
            m_base  = wb;
            m_bound = wz;
        end
    endtask

    // Monitor: 5 ns after each edge, compare the result of the request captured there.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (grant !== e.grant || mem_trap !== e.trap || int'(phys_addr) != int'(e.phys)) begin
                    n_bad++;
                    $display("FAIL %s: got grant=%0b trap=%0b phys=%0d, expected grant=%0b trap=%0b phys=%0d",
                             e.req, grant, mem_trap, phys_addr, e.grant, e.trap, e.phys);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report_and_end();
    end

    initial begin
        m_base  = 0;
        m_bound = MEM_WORDS;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs are quiet straight after reset
        n_cmp++;
        if (grant !== 1'b0 || mem_trap !== 1'b0 || phys_addr !== '0) begin
            n_bad++;
            $display("FAIL R1 reset outputs: got %0b/%0b/%0d, expected 0/0/0", grant, mem_trap, phys_addr);
        end
        drive(1, MEM_WORDS-1, 0, 0, 0, "R1 top word of full window");
        drive(1, MEM_WORDS,   0, 0, 0, "R1 first word past memory");
        drive(0, 123,         0, 0, 0, "R2 idle cycle");
        drive(1, 7,           0, 0, 0, "R3 identity relocation");
        // R8: the request on the write edge still sees the old window
        drive(1, 600, 1, 1000, 500, "R8 request on write edge");
        drive(1, 499, 0, 0, 0, "R5 size-1 granted");
        drive(1, 500, 0, 0, 0, "R5 address equal to size traps");
        drive(1, 0,   0, 0, 0, "R3 base plus zero");
        drive(1, 250, 0, 0, 0, "R3 relocated middle");
        drive(0, 0,   1, 39000, 2000, "R2 idle while writing");
        drive(1, 999,  0, 0, 0, "R4 last memory word");
        drive(1, 1000, 0, 0, 0, "R4 sum equal to memory size traps");
        drive(1, 1500, 0, 0, 0, "R4 inside size, past memory");
        drive(0, 0,    1, 65000, 65535, "R2 idle while writing");
        drive(1, 1000, 0, 0, 0, "R6 carry out must trap");
        drive(1, 65535, 0, 0, 0, "R6 largest sum traps");
        drive(0, 0, 1, 0, 0, "R2 idle while writing");
        drive(1, 0, 0, 0, 0, "R9 zero size traps address 0");
        drive(1, 5, 0, 0, 0, "R9 zero size traps address 5");
        drive(1, 9, 1, 0, MEM_WORDS, "R8 write back full window, old rule applies");
        drive(1, 12345, 0, 0, 0, "R3 full window granted");
        drive(1, 1, 1, 39999, 1, "R7 granted before one-word window");
        drive(1, 0, 0, 0, 0, "R7 one-word window at memory top");
        drive(1, 1, 0, 0, 0, "R7 one-word window, second word traps");
        for (int k = 0; k < 400; k++) begin
            bit do_wr;
            do_wr = ($urandom_range(0, 7) == 0);
            drive($urandom_range(0, 3) != 0, $urandom_range(0, 65535), do_wr,
                  $urandom_range(0, 65535), $urandom_range(0, 1 << PA_W), "R3 R4 R5 random mix");
        end
        drive(0, 0, 0, 0, 0, "R2 closing idle");
        @(negedge clk);
        report_and_end();
    end

endmodule